// File: doc/BRIEF.md
# Host-to-PCI Bridge Window Decoder

The block sits between a CPU-side request/response port and a downstream PCI-side request port. Each CPU access is matched against three address windows: a control-register window, an I/O window and a memory window. Each window answers at two physical bases that differ by a fixed alias step. Memory and I/O accesses are forwarded downstream after a programmable base register is added to their offset inside the window, and they keep their byte, halfword or word size. The register window is served locally. It holds a 32-bit configuration header image, the two base registers and a configuration address register. One port in this window is forwarded: a 4-byte downstream configuration cycle at the address held in the configuration address register.

Only one access is in flight at a time. `cpu_req_ready` is high only while the controller is idle. Forwarded accesses hold `ds_req_valid` until `ds_ack`, and every access ends with a one-cycle `cpu_rsp_valid` pulse.

The controller has three states. IDLE accepts a request. It takes the transition *forward* to FWD_WAIT for memory, I/O and configuration-data accesses, and the transition *local* to RESPOND for everything else (register reads and writes, ignored narrow accesses, misses). FWD_WAIT takes *acknowledge* to RESPOND when `ds_ack` is seen. RESPOND takes *complete* back to IDLE after one cycle.

Top module: `pci_window_bridge`

## Requirements
- R1: After reset, `cpu_req_ready` is 1 and `cpu_rsp_valid` and `ds_req_valid` are 0. A word read at register offset 0x000 returns {DEVICE_ID, VENDOR_ID} (default 0x350E1054), and offset 0x004 returns 0x02900080, so header bytes 4..7 are 0x80, 0x00, 0x90, 0x02.
- R2: The windows decode at base B and alias B+0xE0000000. Register window: B=0x1E200000, 0x224 bytes. I/O window: B=0x1E240000, 0x40000 bytes. Memory window: B=0x1D000000, 0x1000000 bytes.
- R3: A memory-window access is forwarded with `ds_req_type`=1 and `ds_req_addr` = offset + memory base. `ds_req_size` equals `cpu_size` (0 byte, 1 halfword, 2 word), and write flag and data are unchanged.
- R4: An I/O-window access is forwarded with `ds_req_type`=2 and `ds_req_addr` = offset + I/O base, with the original size.
- R5: Word accesses at register offsets 0x000..0x0FF read and write header word offset/4, little-endian, with byte offset 4k in bits 7:0. Word 0 (the ID word) is read-only.
- R6: The word at 0x1C0 is the configuration address register (read/write). A word write at 0x220 issues `ds_req_type`=0, size 2, write, at the configuration address. A word read at 0x220 returns the downstream read data.
- R7: The memory base is at 0x1C4 and the I/O base is at 0x1C8. Both are read/write, reset to 0, and change only on a word write to their own offset.
- R8: Byte or halfword accesses, and misaligned word accesses, to the register window are ignored on write, return 0 on read, raise no error and send nothing downstream.
- R9: An access outside all windows, or with `cpu_size`=3, gets `cpu_rsp_valid` in the cycle after acceptance with `cpu_rsp_err`=1 and read data 0, and sends nothing downstream.
- R10: A forwarded access keeps the downstream request stable until `ds_ack`. The CPU response comes in the cycle after `ds_ack`, and `cpu_req_ready` stays low meanwhile. A local access responds in the cycle after acceptance. Write responses carry read data 0.
- R11: Word-aligned register offsets 0x100..0x21F other than 0x1C0, 0x1C4 and 0x1C8 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Bridge can accept a request |
| cpu_addr | input | 32 | CPU physical address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| cpu_we | input | 1 | 1 for write |
| cpu_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_rdata | output | 32 | Read data |
| cpu_rsp_err | output | 1 | Access missed every window or had bad size |
| ds_req_valid | output | 1 | Downstream request pending |
| ds_req_type | output | 2 | 0 configuration, 1 memory, 2 I/O |
| ds_req_addr | output | 32 | Translated downstream address |
| ds_req_size | output | 2 | Access size code |
| ds_req_we | output | 1 | Downstream write |
| ds_req_wdata | output | 32 | Downstream write data |
| ds_ack | input | 1 | Downstream completion |
| ds_rdata | input | 32 | Downstream read data, valid with ds_ack |

## Verification
The forwarding path is tried with a vector table that mixes memory and I/O windows, both alias bases, all three sizes, reads and writes, and offsets at each window's first and last bytes. Base registers are set to distinct nonzero values, so a missing base add, a wrong window type or a lost alias each shows up as a wrong downstream address or type. Directed tests then separate local from forwarded register-window traffic (header, base, configuration-address and reserved words against the configuration-data port) and narrow from word accesses. Misses just past each window's end tell an off-by-one span from a correct one, and response latency is measured with two downstream delays.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
    typedef enum logic [1:0] {WIN_NONE = 2'd0, WIN_REG = 2'd1, WIN_IO = 2'd2, WIN_MEM = 2'd3} win_e;
    typedef enum logic [1:0] {DS_CFG = 2'd0, DS_MEM = 2'd1, DS_IO = 2'd2} ds_kind_e;
    typedef enum logic [2:0] {RK_HDR, RK_CADDR, RK_CDATA, RK_MBASE, RK_IOBASE, RK_RSVD} rkind_e;
    typedef enum logic [1:0] {ST_IDLE, ST_FWD_WAIT, ST_RESPOND} state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [31:0] OFS_CADDR  = 32'h0000_01C0;
    localparam logic [31:0] OFS_MBASE  = 32'h0000_01C4;
    localparam logic [31:0] OFS_IOBASE = 32'h0000_01C8;
    localparam logic [31:0] OFS_CDATA  = 32'h0000_0220;
endpackage

// File: rtl/pwb_decode.sv
`timescale 1ns/1ps
module pwb_decode
    import pwb_pkg::*;
#(
    parameter logic [31:0] REG_BASE   = 32'h1E20_0000,
    parameter logic [31:0] REG_SPAN   = 32'h0000_0224,
    parameter logic [31:0] IO_BASE    = 32'h1E24_0000,
    parameter logic [31:0] IO_SPAN    = 32'h0004_0000,
    parameter logic [31:0] MEM_BASE   = 32'h1D00_0000,
    parameter logic [31:0] MEM_SPAN   = 32'h0100_0000,
    parameter int          N_ALIAS    = 2,
    parameter logic [31:0] ALIAS_STEP = 32'hE000_0000
) (
    input  logic [31:0] addr,
    output win_e        win,
    output logic [31:0] offset
);
    localparam int NW = 3;
    localparam int NE = NW * N_ALIAS;
    localparam logic [31:0] BASES [NW] = '{REG_BASE, IO_BASE, MEM_BASE};
    localparam logic [31:0] SPANS [NW] = '{REG_SPAN, IO_SPAN, MEM_SPAN};
    localparam win_e        TAGS  [NW] = '{WIN_REG, WIN_IO, WIN_MEM};

    logic [NE-1:0] hit;
    logic [31:0]   rel [NE];
    win_e          tag [NE];

    for (genvar w = 0; w < NW; w++) begin : g_win
        for (genvar a = 0; a < N_ALIAS; a++) begin : g_alias
            localparam logic [31:0] B = BASES[w] + 32'(a) * ALIAS_STEP;
            localparam int          I = w * N_ALIAS + a;
            assign rel[I] = addr - B;
            assign hit[I] = (addr >= B) && (rel[I] < SPANS[w]);
            assign tag[I] = TAGS[w];
        end
    end

    always_comb begin
        win    = WIN_NONE;
        offset = '0;
        for (int i = 0; i < NE; i++) begin
            if (hit[i]) begin
                win    = tag[i];
                offset = rel[i];
            end
        end
    end
endmodule

// File: rtl/pwb_regfile.sv
`timescale 1ns/1ps
module pwb_regfile
    import pwb_pkg::*;
#(
    parameter int          HDR_WORDS = 64,
    parameter logic [15:0] VENDOR_ID = 16'h1054,
    parameter logic [15:0] DEVICE_ID = 16'h350E,
    parameter logic [31:0] HDR1_INIT = 32'h0290_0080
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] offset,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output rkind_e      kind,
    output logic [31:0] rd_data,
    output logic [31:0] mem_base,
    output logic [31:0] io_base,
    output logic [31:0] cfg_addr
);
    localparam int          IDX_W     = $clog2(HDR_WORDS);
    localparam logic [31:0] HDR_BYTES = 32'(HDR_WORDS * 4);

    logic [31:0]      hdr [HDR_WORDS];
    logic [IDX_W-1:0] idx;

    assign idx = offset[IDX_W+1:2];

    always_comb begin
        if (offset[1:0] != 2'b00)         kind = RK_RSVD;
        else if (offset < HDR_BYTES)      kind = RK_HDR;
        else if (offset == OFS_CADDR)     kind = RK_CADDR;
        else if (offset == OFS_MBASE)     kind = RK_MBASE;
        else if (offset == OFS_IOBASE)    kind = RK_IOBASE;
        else if (offset == OFS_CDATA)     kind = RK_CDATA;
        else                              kind = RK_RSVD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HDR_WORDS; i++) hdr[i] <= (i == 1) ? HDR1_INIT : 32'h0;
            mem_base <= '0;
            io_base  <= '0;
            cfg_addr <= '0;
        end else if (wr_en) begin
            unique case (kind)
                RK_HDR:    if (idx != '0) hdr[idx] <= wr_data;
                RK_CADDR:  cfg_addr <= wr_data;
                RK_MBASE:  mem_base <= wr_data;
                RK_IOBASE: io_base  <= wr_data;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (kind)
            RK_HDR:    rd_data = (idx == '0) ? {DEVICE_ID, VENDOR_ID} : hdr[idx];
            RK_CADDR:  rd_data = cfg_addr;
            RK_MBASE:  rd_data = mem_base;
            RK_IOBASE: rd_data = io_base;
            default:   rd_data = '0;
        endcase
    end

    // base registers move only under a write strobe
    assert_base_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_base) && $stable(io_base));
endmodule

// File: rtl/pwb_ctrl.sv
`timescale 1ns/1ps
module pwb_ctrl
    import pwb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    output logic        cpu_req_ready,
    input  logic [1:0]  cpu_size,
    input  logic        cpu_we,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_rsp_valid,
    output logic [31:0] cpu_rsp_rdata,
    output logic        cpu_rsp_err,
    input  win_e        win,
    input  logic [31:0] offset,
    input  rkind_e      kind,
    input  logic [31:0] rf_rdata,
    input  logic [31:0] mem_base,
    input  logic [31:0] io_base,
    input  logic [31:0] cfg_addr,
    output logic        rf_wr_en,
    output logic        ds_req_valid,
    output logic [1:0]  ds_req_type,
    output logic [31:0] ds_req_addr,
    output logic [1:0]  ds_req_size,
    output logic        ds_req_we,
    output logic [31:0] ds_req_wdata,
    input  logic        ds_ack,
    input  logic [31:0] ds_rdata
);
    state_e      state, state_nx;
    ds_kind_e    q_type;
    logic [31:0] q_addr, q_wdata, q_rdata;
    logic [1:0]  q_size;
    logic        q_we, q_err;
    logic        accept, bad, narrow, to_cfg, fwd;

    assign accept = cpu_req_valid && (state == ST_IDLE);
    assign bad    = (win == WIN_NONE) || (cpu_size == 2'd3);
    assign narrow = (win == WIN_REG) && (cpu_size != SZ_WORD);
    assign to_cfg = (win == WIN_REG) && (cpu_size == SZ_WORD) && (kind == RK_CDATA);
    assign fwd    = !bad && ((win == WIN_IO) || (win == WIN_MEM) || to_cfg);
    assign rf_wr_en = accept && cpu_we && !bad && (win == WIN_REG) && !narrow && !to_cfg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept) state_nx = fwd ? ST_FWD_WAIT : ST_RESPOND;
            ST_FWD_WAIT: if (ds_ack) state_nx = ST_RESPOND;
            ST_RESPOND:  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_type  <= DS_CFG;
            q_addr  <= '0;
            q_wdata <= '0;
            q_size  <= SZ_BYTE;
            q_we    <= 1'b0;
            q_rdata <= '0;
            q_err   <= 1'b0;
        end else if (accept) begin
            q_err   <= bad;
            q_rdata <= (bad || narrow || cpu_we) ? 32'h0 : rf_rdata;
            if (fwd) begin
                q_we    <= cpu_we;
                q_wdata <= cpu_wdata;
                q_size  <= cpu_size;
                if (win == WIN_MEM) begin
                    q_type <= DS_MEM;
                    q_addr <= offset + mem_base;
                end else if (win == WIN_IO) begin
                    q_type <= DS_IO;
                    q_addr <= offset + io_base;
                end else begin
                    q_type <= DS_CFG;
                    q_addr <= cfg_addr;
                end
            end
        end else if (state == ST_FWD_WAIT && ds_ack) begin
            q_rdata <= q_we ? 32'h0 : ds_rdata;
        end
    end

    always_comb begin
        cpu_req_ready = (state == ST_IDLE);
        cpu_rsp_valid = (state == ST_RESPOND);
        cpu_rsp_rdata = q_rdata;
        cpu_rsp_err   = q_err;
        ds_req_valid  = (state == ST_FWD_WAIT);
        ds_req_type   = q_type;
        ds_req_addr   = q_addr;
        ds_req_size   = q_size;
        ds_req_we     = q_we;
        ds_req_wdata  = q_wdata;
    end

    assert_ds_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_valid && !ds_ack |=> ds_req_valid && $stable(ds_req_addr) && $stable(ds_req_type));
    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid && cpu_req_ready);
    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid && cpu_rsp_err |-> cpu_rsp_rdata == 32'h0);
    assert_miss_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (win == WIN_NONE) |=> cpu_rsp_valid && cpu_rsp_err);
    assert_cfg_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_valid && (ds_req_type == 2'd0) |-> ds_req_size == SZ_WORD && ds_req_addr == cfg_addr);
endmodule

// File: rtl/pci_window_bridge.sv
`timescale 1ns/1ps
module pci_window_bridge
    import pwb_pkg::*;
#(
    parameter logic [31:0] REG_BASE   = 32'h1E20_0000,
    parameter logic [31:0] REG_SPAN   = 32'h0000_0224,
    parameter logic [31:0] IO_BASE    = 32'h1E24_0000,
    parameter logic [31:0] IO_SPAN    = 32'h0004_0000,
    parameter logic [31:0] MEM_BASE   = 32'h1D00_0000,
    parameter logic [31:0] MEM_SPAN   = 32'h0100_0000,
    parameter int          N_ALIAS    = 2,
    parameter logic [31:0] ALIAS_STEP = 32'hE000_0000,
    parameter int          HDR_WORDS  = 64,
    parameter logic [15:0] VENDOR_ID  = 16'h1054,
    parameter logic [15:0] DEVICE_ID  = 16'h350E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    output logic        cpu_req_ready,
    input  logic [31:0] cpu_addr,
    input  logic [1:0]  cpu_size,
    input  logic        cpu_we,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_rsp_valid,
    output logic [31:0] cpu_rsp_rdata,
    output logic        cpu_rsp_err,
    output logic        ds_req_valid,
    output logic [1:0]  ds_req_type,
    output logic [31:0] ds_req_addr,
    output logic [1:0]  ds_req_size,
    output logic        ds_req_we,
    output logic [31:0] ds_req_wdata,
    input  logic        ds_ack,
    input  logic [31:0] ds_rdata
);
    win_e        win;
    rkind_e      kind;
    logic [31:0] offset, rf_rdata, mem_base, io_base, cfg_addr;
    logic        rf_wr_en;

    pwb_decode #(
        .REG_BASE(REG_BASE), .REG_SPAN(REG_SPAN), .IO_BASE(IO_BASE), .IO_SPAN(IO_SPAN),
        .MEM_BASE(MEM_BASE), .MEM_SPAN(MEM_SPAN), .N_ALIAS(N_ALIAS), .ALIAS_STEP(ALIAS_STEP)
    ) u_decode (
        .addr(cpu_addr), .win(win), .offset(offset)
    );

    pwb_regfile #(
        .HDR_WORDS(HDR_WORDS), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .offset(offset), .wr_en(rf_wr_en), .wr_data(cpu_wdata),
        .kind(kind), .rd_data(rf_rdata), .mem_base(mem_base), .io_base(io_base), .cfg_addr(cfg_addr)
    );

    pwb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_size(cpu_size), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_err(cpu_rsp_err),
        .win(win), .offset(offset), .kind(kind), .rf_rdata(rf_rdata),
        .mem_base(mem_base), .io_base(io_base), .cfg_addr(cfg_addr), .rf_wr_en(rf_wr_en),
        .ds_req_valid(ds_req_valid), .ds_req_type(ds_req_type), .ds_req_addr(ds_req_addr),
        .ds_req_size(ds_req_size), .ds_req_we(ds_req_we), .ds_req_wdata(ds_req_wdata),
        .ds_ack(ds_ack), .ds_rdata(ds_rdata)
    );
endmodule

// File: tb/tb_pci_window_bridge.sv
`timescale 1ns/1ps
module tb_pci_window_bridge;
    localparam logic [31:0] MAGIC = 32'h5A5A_0000;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  sz;
        logic        we;
        logic [31:0] wdata;
        logic [1:0]  dtype;
        logic [31:0] daddr;
    } vec_t;

    // memory base 0x40000000, I/O base 0x1000 programmed before the walk
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h1D00_0000, 2'd2, 1'b0, 32'h0,         2'd1, 32'h4000_0000},
        '{32'hFD00_0010, 2'd0, 1'b1, 32'h0000_00AB, 2'd1, 32'h4000_0010},
        '{32'h1DFF_FFFE, 2'd1, 1'b0, 32'h0,         2'd1, 32'h40FF_FFFE},
        '{32'h1E24_0000, 2'd0, 1'b0, 32'h0,         2'd2, 32'h0000_1000},
        '{32'hFE27_FFFC, 2'd2, 1'b1, 32'hCAFE_F00D, 2'd2, 32'h0004_0FFC},
        '{32'h1E24_0102, 2'd1, 1'b0, 32'h0,         2'd2, 32'h0000_1102},
        '{32'hFDFF_FFFC, 2'd2, 1'b1, 32'h1234_5678, 2'd1, 32'h40FF_FFFC}
    };

    logic        clk = 0, rst_n = 0;
    logic        cpu_req_valid = 0, cpu_we = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0;
    logic [1:0]  cpu_size = 0;
    logic        cpu_req_ready, cpu_rsp_valid, cpu_rsp_err;
    logic [31:0] cpu_rsp_rdata;
    logic        ds_req_valid, ds_req_we;
    logic [1:0]  ds_req_type, ds_req_size;
    logic [31:0] ds_req_addr, ds_req_wdata;
    logic        ds_ack = 0;
    logic [31:0] ds_rdata = 0;

    int checks = 0, errors = 0;
    int resp_lat = 2, wcnt = 0, ds_cnt = 0;
    logic [1:0]  l_type, l_size;
    logic [31:0] l_addr, l_wdata;
    logic        l_we;
    logic [31:0] rd;
    logic        er;
    int          lat;
    bit          rdy_bad;

    always #2 clk = ~clk;

    pci_window_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_err(cpu_rsp_err),
        .ds_req_valid(ds_req_valid), .ds_req_type(ds_req_type), .ds_req_addr(ds_req_addr),
        .ds_req_size(ds_req_size), .ds_req_we(ds_req_we), .ds_req_wdata(ds_req_wdata),
        .ds_ack(ds_ack), .ds_rdata(ds_rdata)
    );

    // downstream responder: acknowledges after resp_lat cycles of request
    initial forever begin
        @(negedge clk);
        if (ds_ack) ds_ack = 1'b0;
        else if (ds_req_valid) begin
            wcnt++;
            if (wcnt >= resp_lat) begin
                wcnt = 0;
                ds_cnt++;
                l_type = ds_req_type; l_addr = ds_req_addr; l_size = ds_req_size;
                l_we = ds_req_we; l_wdata = ds_req_wdata;
                ds_rdata = ds_req_addr ^ MAGIC;
                ds_ack = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic we,
                          input logic [31:0] wd);
        @(negedge clk);
        cpu_req_valid = 1; cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd;
        @(posedge clk);
        #1 cpu_req_valid = 0;
        lat = 0; rdy_bad = 0;
        do begin
            @(negedge clk);
            lat++;
            if (!cpu_rsp_valid && cpu_req_ready) rdy_bad = 1;
        end while (!cpu_rsp_valid && lat < 100);
        rd = cpu_rsp_rdata;
        er = cpu_rsp_err;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(cpu_req_ready), 32'd1);
        chk("R1 rsp idle after reset", 32'(cpu_rsp_valid), 32'd0);
        chk("R1 ds idle after reset", 32'(ds_req_valid), 32'd0);

        access(32'h1E20_0000, 2'd2, 0, 0);
        chk("R1 id word", rd, 32'h350E_1054);
        access(32'h1E20_0004, 2'd2, 0, 0);
        chk("R1 header word1", rd, 32'h0290_0080);
        chk("R10 local latency", 32'(lat), 32'd1);
        access(32'hFE20_01C4, 2'd2, 0, 0);
        chk("R7 mem base reset", rd, 32'h0);
        access(32'h1E20_01C8, 2'd2, 0, 0);
        chk("R7 io base reset", rd, 32'h0);

        access(32'h1E20_01C4, 2'd2, 1, 32'h4000_0000);
        access(32'hFE20_01C8, 2'd2, 1, 32'h0000_1000);
        access(32'h1E20_01C4, 2'd2, 0, 0);
        chk("R7 mem base readback", rd, 32'h4000_0000);
        access(32'h1E20_01C8, 2'd2, 0, 0);
        chk("R7 io base readback", rd, 32'h0000_1000);

        // forwarding table walk (R2 R3 R4)
        for (int i = 0; i < NV; i++) begin
            n0 = ds_cnt;
            access(VECS[i].addr, VECS[i].sz, VECS[i].we, VECS[i].wdata);
            chk($sformatf("R3/R4 vec%0d forwarded", i), 32'(ds_cnt - n0), 32'd1);
            chk($sformatf("R3/R4 vec%0d type", i), 32'(l_type), 32'(VECS[i].dtype));
            chk($sformatf("R2 R3/R4 vec%0d addr", i), l_addr, VECS[i].daddr);
            chk($sformatf("R3/R4 vec%0d size", i), 32'(l_size), 32'(VECS[i].sz));
            chk($sformatf("R3 vec%0d we", i), 32'(l_we), 32'(VECS[i].we));
            if (VECS[i].we) chk($sformatf("R3 vec%0d wdata", i), l_wdata, VECS[i].wdata);
            chk($sformatf("R10 vec%0d rdata", i), rd, VECS[i].we ? 32'h0 : (VECS[i].daddr ^ MAGIC));
            chk($sformatf("R9 vec%0d no err", i), 32'(er), 32'd0);
            chk($sformatf("R10 vec%0d latency", i), 32'(lat), 32'd3);
        end

        // header through both aliases
        access(32'hFE20_0008, 2'd2, 1, 32'h1122_3344);
        access(32'h1E20_0008, 2'd2, 0, 0);
        chk("R5 R2 header alias readback", rd, 32'h1122_3344);
        access(32'h1E20_00FC, 2'd2, 1, 32'hA1B2_C3D4);
        access(32'hFE20_00FC, 2'd2, 0, 0);
        chk("R5 last header word", rd, 32'hA1B2_C3D4);
        access(32'h1E20_0000, 2'd2, 1, 32'hFFFF_FFFF);
        access(32'h1E20_0000, 2'd2, 0, 0);
        chk("R5 id word read-only", rd, 32'h350E_1054);

        // narrow and misaligned register accesses
        n0 = ds_cnt;
        access(32'h1E20_0008, 2'd1, 1, 32'h0000_FFFF);
        access(32'h1E20_0009, 2'd0, 1, 32'h0000_00EE);
        access(32'h1E20_000A, 2'd2, 1, 32'hDEAD_DEAD);
        access(32'h1E20_0008, 2'd0, 0, 0);
        chk("R8 byte read zero", rd, 32'h0);
        chk("R8 byte read no err", 32'(er), 32'd0);
        access(32'h1E20_0008, 2'd2, 0, 0);
        chk("R8 narrow writes ignored", rd, 32'h1122_3344);
        chk("R8 nothing downstream", 32'(ds_cnt - n0), 32'd0);

        // reserved words
        access(32'h1E20_0100, 2'd2, 1, 32'hFFFF_FFFF);
        access(32'h1E20_0100, 2'd2, 0, 0);
        chk("R11 reserved reads zero", rd, 32'h0);
        access(32'h1E20_021C, 2'd2, 1, 32'h5555_5555);
        access(32'h1E20_021C, 2'd2, 0, 0);
        chk("R11 reserved top word", rd, 32'h0);

        // configuration access
        access(32'h1E20_01C0, 2'd2, 1, 32'h8000_0810);
        access(32'h1E20_01C0, 2'd2, 0, 0);
        chk("R6 cfg addr readback", rd, 32'h8000_0810);
        n0 = ds_cnt;
        access(32'hFE20_0220, 2'd2, 1, 32'hDEAD_BEEF);
        chk("R6 cfg write forwarded", 32'(ds_cnt - n0), 32'd1);
        chk("R6 cfg write type", 32'(l_type), 32'd0);
        chk("R6 cfg write addr", l_addr, 32'h8000_0810);
        chk("R6 cfg write size", 32'(l_size), 32'd2);
        chk("R6 cfg write data", l_wdata, 32'hDEAD_BEEF);
        chk("R6 cfg write we", 32'(l_we), 32'd1);
        access(32'h1E20_0220, 2'd2, 0, 0);
        chk("R6 cfg read data", rd, 32'h8000_0810 ^ MAGIC);
        chk("R6 cfg read we", 32'(l_we), 32'd0);

        // misses
        n0 = ds_cnt;
        access(32'h1E20_0224, 2'd2, 0, 0);
        chk("R9 past reg window err", 32'(er), 32'd1);
        chk("R9 miss data zero", rd, 32'h0);
        chk("R9 miss latency", 32'(lat), 32'd1);
        access(32'h1E28_0000, 2'd0, 0, 0);
        chk("R9 past io window err", 32'(er), 32'd1);
        access(32'h1CFF_FFFF, 2'd0, 1, 32'h1);
        chk("R9 below mem window err", 32'(er), 32'd1);
        access(32'hFE00_0000, 2'd2, 0, 0);
        chk("R9 past mem alias err", 32'(er), 32'd1);
        access(32'h1D00_0100, 2'd3, 0, 0);
        chk("R9 bad size err", 32'(er), 32'd1);
        chk("R9 misses not forwarded", 32'(ds_cnt - n0), 32'd0);

        // slower downstream
        resp_lat = 4;
        access(32'h1D00_0040, 2'd2, 0, 0);
        chk("R10 slow latency", 32'(lat), 32'd5);
        chk("R10 ready low while waiting", 32'(rdy_bad), 32'd0);
        chk("R10 slow read data", rd, 32'h4000_0040 ^ MAGIC);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule